// File: doc/BRIEF.md
# PDM microphone capture front-end

This block drives the bit clock for external single-bit pulse-density microphones and captures what they send. A fast master clock is divided down by a ratio of 4, 8, 16 or 32, picked by a 2-bit code. The source clock family sets the microphone clock rate. A 24.576 MHz master gives 6.144 MHz down to 768 kHz. A 22.5792 MHz master gives 5.6448 MHz down to 705.6 kHz. Each of the two serial data lines is shared by two microphones. One microphone places its bit in the high half of the microphone clock and the other in the low half.

Each of the four channels picks its own capture edge. Every channel emits one bit per microphone clock period, with a single-cycle valid strobe, to a later decimation stage. A 2-bit source field per channel marks it as digital or analog. An analog channel produces no strobes. A digital channel flags its analog path as powered down and bypassed.

Top module: `pdm_capture`

## Requirements
- R1: Divider code 0, 1, 2 or 3 makes `pdm_clk_o` run at master clock / 4, 8, 16 or 32. The clock has a 50% duty cycle, and each period starts with its low half.
- R2: A new divider code takes effect only when the internal period counter wraps, at the start of a low half. Every high half is exactly as long as the low half before it, so no runt pulse appears.
- R3: While `rst_ni` is low or `en_i` is low, `pdm_clk_o` is 0 and every bit of `ch_valid_o` is 0.
- R4: Channels 0 and 1 take their bits from `pdm_din_i[0]`. Channels 2 and 3 take theirs from `pdm_din_i[1]`.
- R5: When `edge_sel_i[k]` is 0, channel k samples just before the rising edge, and its strobe comes in the first master cycle of the high half. When `edge_sel_i[k]` is 1, it samples just before the falling edge, and its strobe comes in the first master cycle of the low half.
- R6: A digital channel asserts `ch_valid_o[k]` exactly once per microphone clock period, for one master cycle.
- R7: Channel k is digital only when `src_sel_i[2k+1:2k]` is 2'b10. Codes 00, 01 and 11 are analog, and an analog channel never asserts valid. `analog_pd_o[k]` is 1 exactly when channel k is digital.
- R8: Data passes through a two-flop synchronizer and one capture register. The `ch_bit_o[k]` value shown with a strobe is the line value that was present three master cycles before the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Capture enable |
| div_sel_i | input | 2 | Divider code (ratio 4 << code) |
| edge_sel_i | input | 4 | Per-channel capture edge, 0 rising, 1 falling |
| src_sel_i | input | 8 | Per-channel 2-bit source field, 2'b10 digital |
| pdm_din_i | input | 2 | Shared microphone data lines |
| pdm_clk_o | output | 1 | Microphone bit clock |
| ch_bit_o | output | 4 | Captured bit per channel |
| ch_valid_o | output | 4 | One-cycle strobe per channel |
| analog_pd_o | output | 4 | Analog path powered down for digital channels |

## Verification
A captured bit is due three master cycles after its line value is applied: two synchronizer flops plus the capture register. The bench keeps the last three applied line values and compares each strobe against the oldest of them. A strobe and the microphone clock edge it belongs to show up in the same sampled cycle. The bench therefore checks the clock level and the previous sampled level in the very cycle the strobe is seen. Half-period lengths and strobe counts per period are judged when each clock transition is observed. The divider code is only required to match once 80 cycles have passed since the last code change, which leaves room for the old period to finish.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int BASE_SHIFT = 2;  // smallest ratio is 1 << BASE_SHIFT

  typedef enum logic [1:0] {
    SRC_ANA_DIFF = 2'b00,
    SRC_ANA_SE   = 2'b01,
    SRC_DIGITAL  = 2'b10,
    SRC_ANA_RSVD = 2'b11
  } src_sel_e;

  function automatic logic is_digital(input logic [1:0] code);
    return code == SRC_DIGITAL;
  endfunction
endpackage

// File: rtl/pdm_sync.sv
module pdm_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
  import pdm_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             pdm_clk_o,
  output logic             rise_pre_o,
  output logic             fall_pre_o
);
  localparam int MAX_SHIFT = BASE_SHIFT + (1 << DIV_W) - 1;
  localparam int CNT_W     = MAX_SHIFT;

  logic [DIV_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] last, half_m1;

  always_comb begin
    ratio   = (CNT_W + 1)'(1) << (BASE_SHIFT + int'(code_q));
    last    = CNT_W'(ratio - 1'b1);
    half_m1 = CNT_W'((ratio >> 1) - 1'b1);
  end

  // code reloads only at wrap, i.e. entering a low half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
      clk_q  <= 1'b0;
    end else if (!en_i || cnt_q == last) begin
      cnt_q  <= '0;
      code_q <= div_sel_i;
      clk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      clk_q  <= cnt_q >= half_m1;
    end
  end

  assign pdm_clk_o  = clk_q & en_i;
  assign rise_pre_o = en_i && cnt_q == half_m1;
  assign fall_pre_o = en_i && cnt_q == last;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);  // R1
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != last) |=> $stable(code_q));  // R2
  AST_IDLE_COUNTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !clk_q));  // R3
endmodule

// File: rtl/pdm_chan_capture.sv
module pdm_chan_capture
  import pdm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       din_i,
  input  logic       edge_sel_i,
  input  logic [1:0] src_i,
  input  logic       rise_pre_i,
  input  logic       fall_pre_i,
  output logic       bit_o,
  output logic       valid_o,
  output logic       analog_pd_o
);
  logic dig;
  logic take;
  logic bit_q, valid_q;

  assign dig  = is_digital(src_i);
  assign take = en_i && dig && (edge_sel_i ? fall_pre_i : rise_pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) bit_q <= din_i;
    end
  end

  assign bit_o       = bit_q;
  assign valid_o     = valid_q & en_i;
  assign analog_pd_o = dig;

  AST_ANALOG_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(dig));  // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R6
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
  import pdm_pkg::*;
#(
  parameter int N_LINES     = 2,
  parameter int CH_PER_LINE = 2,
  parameter int DIV_W       = 2,
  localparam int N_CH       = N_LINES * CH_PER_LINE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [N_CH-1:0]   edge_sel_i,
  input  logic [2*N_CH-1:0] src_sel_i,
  input  logic [N_LINES-1:0] pdm_din_i,
  output logic              pdm_clk_o,
  output logic [N_CH-1:0]   ch_bit_o,
  output logic [N_CH-1:0]   ch_valid_o,
  output logic [N_CH-1:0]   analog_pd_o
);
  logic [N_LINES-1:0] din_s;
  logic rise_pre, fall_pre;

  pdm_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .div_sel_i (div_sel_i),
    .pdm_clk_o (pdm_clk_o),
    .rise_pre_o(rise_pre),
    .fall_pre_o(fall_pre)
  );

  pdm_sync #(.W(N_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pdm_din_i),
    .q_o   (din_s)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    pdm_chan_capture u_cap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .din_i      (din_s[k / CH_PER_LINE]),
      .edge_sel_i (edge_sel_i[k]),
      .src_i      (src_sel_i[2*k +: 2]),
      .rise_pre_i (rise_pre),
      .fall_pre_i (fall_pre),
      .bit_o      (ch_bit_o[k]),
      .valid_o    (ch_valid_o[k]),
      .analog_pd_o(analog_pd_o[k])
    );

    AST_RISE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_valid_o[k] && !$past(edge_sel_i[k])) |-> (pdm_clk_o && !$past(pdm_clk_o)));  // R5
    AST_FALL_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_valid_o[k] && $past(edge_sel_i[k])) |-> (!pdm_clk_o && $past(pdm_clk_o)));  // R5
  end

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!pdm_clk_o && ch_valid_o == '0));  // R3
endmodule

// File: tb/pdm_capture_bench.sv
module pdm_capture_bench;
  localparam int N_CH = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic [3:0] edge_sel_i = 4'd0;
  logic [7:0] src_sel_i = 8'd0;
  logic [1:0] pdm_din_i = 2'd0;
  logic       pdm_clk_o;
  logic [3:0] ch_bit_o, ch_valid_o, analog_pd_o;

  pdm_capture u_pdm_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_sel_i(div_sel_i),
    .edge_sel_i(edge_sel_i), .src_sel_i(src_sel_i), .pdm_din_i(pdm_din_i),
    .pdm_clk_o(pdm_clk_o), .ch_bit_o(ch_bit_o), .ch_valid_o(ch_valid_o),
    .analog_pd_o(analog_pd_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [1:0] dly [3];
  bit prev_clk, low_ok, seen_edge, have_rise;
  int run_len, low_len, since_div;
  int vcnt [N_CH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] c);
    return 2 << c;
  endfunction

  function automatic bit dig_of(input logic [7:0] s, input int k);
    return s[2*k +: 2] == 2'b10;
  endfunction

  task automatic clear_track();
    prev_clk = 0; low_ok = 0; seen_edge = 0; have_rise = 0;
    run_len = 0; low_len = 0;
    for (int k = 0; k < N_CH; k++) vcnt[k] = 0;
  endtask

  task automatic observe();
    bit rise;
    if (!en_i || !rst_ni) begin
      chk(pdm_clk_o == 1'b0, "R3 clk", int'(pdm_clk_o), 0);
      chk(ch_valid_o == 4'd0, "R3 valid", int'(ch_valid_o), 0);
      clear_track();
      return;
    end
    rise = pdm_clk_o && !prev_clk;
    for (int k = 0; k < N_CH; k++) begin
      chk(analog_pd_o[k] == dig_of(src_sel_i, k), "R7 analog_pd", int'(analog_pd_o[k]),
          int'(dig_of(src_sel_i, k)));
      if (ch_valid_o[k]) begin
        chk(dig_of(src_sel_i, k), "R7 analog strobe", 1, 0);
        chk(ch_bit_o[k] == dly[2][k/2], "R4 R8 bit", int'(ch_bit_o[k]), int'(dly[2][k/2]));
        if (!edge_sel_i[k])
          chk(pdm_clk_o && !prev_clk, "R5 rise phase", {pdm_clk_o, prev_clk}, 2);
        else
          chk(!pdm_clk_o && prev_clk, "R5 fall phase", {pdm_clk_o, prev_clk}, 1);
      end
    end
    if (rise) begin
      if (have_rise)
        for (int k = 0; k < N_CH; k++)
          chk(vcnt[k] == int'(dig_of(src_sel_i, k)),
              dig_of(src_sel_i, k) ? "R6 strobes/period" : "R7 strobes/period",
              vcnt[k], int'(dig_of(src_sel_i, k)));
      for (int k = 0; k < N_CH; k++) vcnt[k] = 0;
      have_rise = 1;
    end
    for (int k = 0; k < N_CH; k++) if (ch_valid_o[k]) vcnt[k]++;
    if (pdm_clk_o == prev_clk) run_len++;
    else begin
      if (!prev_clk) begin
        low_len = run_len;
        low_ok  = seen_edge;
      end else if (low_ok) begin
        chk(run_len == low_len, "R2 high==low", run_len, low_len);
        if (since_div > 80)
          chk(run_len == half_of(div_sel_i), "R1 half period", run_len, half_of(div_sel_i));
      end
      seen_edge = 1;
      run_len = 1;
    end
    prev_clk = pdm_clk_o;
  endtask

  task automatic step();
    @(negedge clk_i);
    observe();
    dly[2] = dly[1];
    dly[1] = dly[0];
    pdm_din_i = 2'($urandom);
    dly[0] = pdm_din_i;
    since_div++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_cfg(input logic [1:0] d, input logic [3:0] e, input logic [7:0] s);
    en_i = 1'b0;
    run(4);
    if (d != div_sel_i) since_div = 0;
    div_sel_i = d; edge_sel_i = e; src_sel_i = s;
    en_i = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3; i++) dly[i] = 2'd0;
    clear_track();
    since_div = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(pdm_clk_o == 1'b0 && ch_valid_o == 4'd0, "R3 reset", {pdm_clk_o, ch_valid_o}, 0);
    end
    rst_ni = 1'b1;
    // directed corners
    set_cfg(2'd0, 4'b1010, 8'hAA); run(300);
    set_cfg(2'd3, 4'b0101, 8'hAA); run(400);
    set_cfg(2'd1, 4'b0000, 8'hAA); run(300);
    set_cfg(2'd2, 4'b1111, 8'b10_00_01_10); run(300);
    set_cfg(2'd0, 4'b0011, 8'b11_10_10_00); run(200);
    // random configurations
    for (int r = 0; r < 8; r++) begin
      set_cfg(2'($urandom), 4'($urandom), 8'($urandom));
      run(200 + int'($urandom % 200));
    end
    // divider changes while running
    set_cfg(2'd1, 4'b1001, 8'hAA);
    for (int r = 0; r < 10; r++) begin
      div_sel_i = 2'($urandom);
      since_div = 0;
      run(120 + int'($urandom % 100));
    end
    // disabled window
    en_i = 1'b0;
    run(40);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule